// File: doc/BRIEF.md
# PWM Timer Tick Generator

This block turns one peripheral clock into count-enable ticks for five timer channels. Two 8-bit prescalers divide the peripheral clock. The first serves channels 0 and 1, and the second serves channels 2, 3 and 4. Each channel then does one of two things. It can divide its group's prescaled tick further by a power of two, or it can take one synchronized pulse per rising edge of the external tick input that belongs to its group. Every output is a single-cycle enable in the peripheral clock domain. No output is a derived clock, so downstream counters stay on one clock and advance only when their enable is high.

Software sets up the block through two 32-bit registers on a plain synchronous port. A write takes effect at the clock edge where `cfg_we` is high. Reads are combinational from `cfg_addr`. Register 0 holds the two prescaler ratios. Register 1 holds one 4-bit field per channel, and that one field selects both the divide ratio and the external source. Selecting the external source therefore replaces the divide setting. The port carries control only, so it has no valid/ready handshake and never stalls.

Top module: `pwm_tick_tree`

## Requirements
- R1: After reset both registers read zero, and every channel pulses once every 2 clock cycles.
- R2: Register 0 bits [7:0] hold prescaler 0 and bits [15:8] hold prescaler 1. A field value P gives one prescaled tick every P+1 clocks. Bits [31:16] read zero.
- R3: Channels 0 and 1 use prescaler 0 and external input 0. Channels 2, 3 and 4 use prescaler 1 and external input 1. An input of one group never produces pulses on a channel of the other group.
- R4: The field of channel c sits at register 1 bits [4c+3:4c]. Codes 0, 1, 2 and 3 give one pulse every 2, 4, 8 or 16 prescaled ticks, so the channel period is (P+1)·2^(code+1) clocks.
- R5: A code from 4 to 15 selects the group's external input. The channel then gives exactly one pulse per rising edge of that input, three clock edges after the edge, and the divide setting has no effect.
- R6: Every channel pulse lasts one clock cycle, even when an external input stays high for many cycles.
- R7: A write to register 0 restarts both prescaler counters. Rewrites that come more often than every P+1 clocks therefore suppress all ticks of that prescaler.
- R8: Register 1 bits [31:20] read zero, whatever value was written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_addr | input | 1 | Register select: 0 = prescalers, 1 = channel fields |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the selected register (combinational) |
| ext_tick_in | input | 2 | Asynchronous external tick inputs, one per group |
| ch_tick | output | 5 | One-cycle count-enable pulse per channel |

## Verification
The bench measures steady-state pulse periods for prescaler and divider combinations from P=0 up to P=255 with /16. A design that swaps groups, misplaces a field or drops the +1 would show a wrong period on some channel. It checks that codes above 4 still select the external input, and that an input held high gives one pulse arriving exactly three edges late. A design that decodes only code 4 would stay on the divider, and one without edge detection would emit a train of pulses. Repeated writes to register 0 faster than the period must silence the channel, which a prescaler that is never restarted would fail. Reserved bits must read back as zero.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;
  // width of one per-channel select field
  localparam int unsigned FIELD_W = 4;
  // number of power-of-two divide steps (/2 .. /16)
  localparam int unsigned DIV_STEPS = 4;
  // number of prescaler / external-input groups
  localparam int unsigned NUM_GRP = 2;

  // code >= DIV_STEPS means the external tick source
  function automatic logic code_selects_ext(input logic [FIELD_W-1:0] code);
    return code >= FIELD_W'(DIV_STEPS);
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PSC_W-1:0] ratio,
  output logic             tick
);
  logic [PSC_W-1:0] cnt;

  assign tick = (cnt == ratio);

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (restart || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  // R7: a register write always restarts the count
  assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0))
    else $error("prescaler not restarted");

  // R2: with a ratio above zero, ticks never come back to back
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ratio != '0 && !restart) |=> !tick)
    else $error("prescaler ticked twice in a row");
endmodule

// File: rtl/pwm_ext_sync.sv
module pwm_ext_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic pulse
);
  logic [2:0] stage;

  always_ff @(posedge clk) begin
    if (!rst_n) stage <= '0;
    else        stage <= {stage[1:0], async_in};
  end

  // stage[1] is the second synchronizer flop; stage[2] is its delayed copy
  assign pulse = stage[1] & ~stage[2];

  assert_ext_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse)
    else $error("edge detector pulse longer than one cycle");
endmodule

// File: rtl/pwm_chan_div.sv
module pwm_chan_div
  import pwm_tick_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pre_tick,
  input  logic               ext_pulse,
  input  logic [FIELD_W-1:0] code,
  output logic               tick_out
);
  localparam int unsigned SH_W = $clog2(DIV_STEPS + 1) + 1;

  logic [DIV_STEPS-1:0] dcnt;
  logic [DIV_STEPS:0]   wide_mask;
  logic [SH_W-1:0]      shamt;
  logic                 hit;
  logic                 sel_ext;

  always_ff @(posedge clk) begin
    if (!rst_n)        dcnt <= '0;
    else if (pre_tick) dcnt <= dcnt + 1'b1;
  end

  always_comb begin
    shamt     = SH_W'(code[1:0]) + SH_W'(1);
    wide_mask = ((DIV_STEPS+1)'(1) << shamt) - (DIV_STEPS+1)'(1);
    hit       = (dcnt & wide_mask[DIV_STEPS-1:0]) == wide_mask[DIV_STEPS-1:0];
    sel_ext   = code_selects_ext(code);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tick_out <= 1'b0;
    else        tick_out <= sel_ext ? ext_pulse : (pre_tick & hit);
  end

  // R5: in external mode the output follows only the synchronized edge
  assert_ext_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ext && !ext_pulse) |=> !tick_out)
    else $error("external-mode channel pulsed without an edge");

  // R6: no two-cycle pulses unless the field was rewritten in between
  assert_pulse_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |=> (!tick_out || code != $past(code)))
    else $error("channel pulse wider than one cycle");
endmodule

// File: rtl/pwm_tick_tree.sv
module pwm_tick_tree
  import pwm_tick_pkg::*;
#(
  parameter int unsigned NUM_CH  = 5,
  parameter int unsigned GRP0_CH = 2,
  parameter int unsigned PSC_W   = 8,
  parameter int unsigned CFG_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic [NUM_GRP-1:0] ext_tick_in,
  output logic [NUM_CH-1:0] ch_tick
);
  localparam int unsigned CODE_BITS = NUM_CH * FIELD_W;
  localparam int unsigned PSC_BITS  = NUM_GRP * PSC_W;

  logic [PSC_W-1:0]   psc_q  [NUM_GRP];
  logic [FIELD_W-1:0] code_q [NUM_CH];
  logic [NUM_GRP-1:0] grp_tick;
  logic [NUM_GRP-1:0] grp_ext;
  logic               psc_wr;
  logic               code_wr;

  logic unused_hi;
  assign unused_hi = &{1'b0, cfg_wdata[CFG_W-1:CODE_BITS]};

  assign psc_wr  = cfg_we && !cfg_addr;
  assign code_wr = cfg_we &&  cfg_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < NUM_GRP; g++) psc_q[g] <= '0;
      for (int c = 0; c < NUM_CH; c++)  code_q[c] <= '0;
    end else begin
      if (psc_wr)
        for (int g = 0; g < NUM_GRP; g++) psc_q[g] <= cfg_wdata[g*PSC_W +: PSC_W];
      if (code_wr)
        for (int c = 0; c < NUM_CH; c++) code_q[c] <= cfg_wdata[c*FIELD_W +: FIELD_W];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (!cfg_addr) begin
      for (int g = 0; g < NUM_GRP; g++) cfg_rdata[g*PSC_W +: PSC_W] = psc_q[g];
    end else begin
      for (int c = 0; c < NUM_CH; c++) cfg_rdata[c*FIELD_W +: FIELD_W] = code_q[c];
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    pwm_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(psc_wr),
      .ratio  (psc_q[g]),
      .tick   (grp_tick[g])
    );
    pwm_ext_sync u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_in(ext_tick_in[g]),
      .pulse   (grp_ext[g])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned GRP = (c < GRP0_CH) ? 0 : 1;
    pwm_chan_div u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .pre_tick (grp_tick[GRP]),
      .ext_pulse(grp_ext[GRP]),
      .code     (code_q[c]),
      .tick_out (ch_tick[c])
    );
  end

  // R8 / R2: reserved register bits never read back as set
  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[CFG_W-1:CODE_BITS] == '0)
    else $error("reserved bits read non-zero");

  // R1: the cycle after reset release, all fields are still clear
  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (psc_q[0] == '0 && code_q[0] == '0))
    else $error("registers not cleared by reset");

  logic unused_psc_bits;
  assign unused_psc_bits = &{1'b0, PSC_BITS[0]};
endmodule

// File: tb/pwm_tick_tree_test.sv
module pwm_tick_tree_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_addr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [1:0]  ext_tick_in = '0;
  logic [4:0]  ch_tick;

  int total = 0;
  int bad = 0;
  int pulse_cnt [5];

  always #2.5 clk = ~clk;

  pwm_tick_tree uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ext_tick_in(ext_tick_in), .ch_tick(ch_tick)
  );

  initial for (int i = 0; i < 5; i++) pulse_cnt[i] = 0;
  always @(negedge clk)
    for (int i = 0; i < 5; i++) if (ch_tick[i]) pulse_cnt[i] = pulse_cnt[i] + 1;

  // {psc0, psc1, register 1}
  localparam int NV = 5;
  localparam logic [47:0] VEC [NV] = '{
    {8'd0,   8'd0, 32'h0000_0000},
    {8'd2,   8'd1, 32'h0000_3210},
    {8'd4,   8'd0, 32'h0001_2301},
    {8'd255, 8'd3, 32'h0000_0003},
    {8'd7,   8'd9, 32'h0003_3333}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic addr, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = addr; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic addr, output logic [31:0] data);
    @(negedge clk);
    cfg_addr = addr;
    #1 data = cfg_rdata;
  endtask

  task automatic wait_pulse(input int ch, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!ch_tick[ch] && n < 20000);
  endtask

  task automatic period(input int ch, output int p);
    int n;
    wait_pulse(ch, n);
    wait_pulse(ch, n);
    wait_pulse(ch, n);
    p = n;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    int p, n, snap0, snap1;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values and default ticking
    rd(1'b0, rv); check(rv == 32'h0, "R1 reg0 reset", rv, 0);
    rd(1'b1, rv); check(rv == 32'h0, "R1 reg1 reset", rv, 0);
    for (int c = 0; c < 5; c++) begin
      period(c, p);
      check(p == 2, "R1 default period", p, 2);
    end

    // R2 R3 R4: table of prescaler / divider settings
    for (int v = 0; v < NV; v++) begin
      logic [7:0] p0, p1;
      logic [31:0] r1;
      p0 = VEC[v][47:40]; p1 = VEC[v][39:32]; r1 = VEC[v][31:0];
      wr(1'b0, {16'h0, p1, p0});
      wr(1'b1, r1);
      rd(1'b0, rv);
      check(rv == {16'h0, p1, p0}, "R2 reg0 readback", rv, {16'h0, p1, p0});
      for (int c = 0; c < 5; c++) begin
        int psc, code, expv;
        psc  = (c < 2) ? int'(p0) : int'(p1);
        code = int'(r1[c*4 +: 4]);
        expv = (psc + 1) << (code + 1);
        period(c, p);
        check(p == expv, (c < 2) ? "R4 R3 group0 period" : "R4 R3 group1 period", p, expv);
      end
    end

    // R8 / R2: reserved bits
    wr(1'b1, 32'hFFFF_FFFF);
    rd(1'b1, rv); check(rv == 32'h000F_FFFF, "R8 reg1 reserved", rv, 32'h000F_FFFF);
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, rv); check(rv == 32'h0000_FFFF, "R2 reg0 reserved", rv, 32'h0000_FFFF);

    // R5: ch0 code 4, ch1 code 9 (external); others /2
    wr(1'b0, 32'h0);
    wr(1'b1, 32'h0000_0094);
    repeat (10) @(negedge clk);
    ext_tick_in[0] = 1'b1;
    wait_pulse(0, n);
    check(n == 3, "R5 ext latency", n, 3);
    repeat (6) @(negedge clk);
    ext_tick_in[0] = 1'b0;
    repeat (6) @(negedge clk);
    snap0 = pulse_cnt[0]; snap1 = pulse_cnt[1];
    for (int k = 0; k < 5; k++) begin
      ext_tick_in[0] = 1'b1; repeat (4) @(negedge clk);
      ext_tick_in[0] = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    check(pulse_cnt[0] - snap0 == 5, "R5 code4 edge count", pulse_cnt[0] - snap0, 5);
    check(pulse_cnt[1] - snap1 == 5, "R5 code9 edge count", pulse_cnt[1] - snap1, 5);

    // R6: long high level gives one pulse
    snap0 = pulse_cnt[0];
    ext_tick_in[0] = 1'b1; repeat (20) @(negedge clk);
    ext_tick_in[0] = 1'b0; repeat (6) @(negedge clk);
    check(pulse_cnt[0] - snap0 == 1, "R6 single pulse", pulse_cnt[0] - snap0, 1);

    // R3: group-1 input does not reach group-0 channels
    snap0 = pulse_cnt[0];
    for (int k = 0; k < 3; k++) begin
      ext_tick_in[1] = 1'b1; repeat (4) @(negedge clk);
      ext_tick_in[1] = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    check(pulse_cnt[0] - snap0 == 0, "R3 group isolation", pulse_cnt[0] - snap0, 0);
    period(2, p);
    check(p == 2, "R5 divider channel unaffected", p, 2);

    // R7: frequent prescaler rewrites suppress ticks
    wr(1'b1, 32'h0);
    wr(1'b0, 32'h0000_0007);
    wr(1'b0, 32'h0000_0007);
    snap0 = pulse_cnt[0];
    for (int k = 0; k < 15; k++) begin
      wr(1'b0, 32'h0000_0007);
      @(negedge clk);
    end
    check(pulse_cnt[0] - snap0 == 0, "R7 restart suppresses", pulse_cnt[0] - snap0, 0);
    period(0, p);
    check(p == 16, "R7 period after restarts", p, 16);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule